// File: doc/BRIEF.md
# EEPROM Write Completion Status Reporter

This block is the read path of a byte-wide nonvolatile memory while an internal programming cycle may be running. While no programming is in progress, a read passes the array word at the read address straight to the output bus. While the busy flag is high, a read instead returns two status bits. A polling bit carries the inverse of the most significant bit of the last byte written, when the read targets the last written address. A toggle bit changes value on every new read access. The remaining bits are driven low.

A read access exists while chip select and output enable (both active low) are asserted together. Only then is the bus driven. The block also produces the enable for the external tri-state buffers. An input flag, raised by the write-protection logic after a rejected write, turns off the polling inversion. The toggle bit lives in one flip-flop, which advances at the start of each access. Its value is shown during that access from the first cycle, so it stays constant for the whole access.

Top module: `eeprom_wstat`

## Requirements
- R1: `bus_oe` is 1 exactly when `cs_n` and `oe_n` are both 0; whenever `bus_oe` is 0, `bus_q` is all zeros.
- R2: While `prog_busy` is 1, a read whose `rd_addr` equals `last_addr` with `poll_block` at 0 returns bit 7 (the most significant bit) as the inverse of `last_msb`.
- R3: While `prog_busy` is 1, bit 6 of `bus_q` takes the opposite value at the start of each new read access (first cycle in which both strobes are low after a cycle in which they were not).
- R4: Bit 6 holds one value for every cycle of a single read access, however long the access lasts.
- R5: While `prog_busy` is 1, bits 5 down to 0 of a read are 0.
- R6: While `prog_busy` is 1, a read whose address differs from `last_addr`, or any read while `poll_block` is 1, returns bit 7 equal to bit 7 of `array_q`.
- R7: While `prog_busy` is 0, a read returns `array_q` unchanged, and accesses made then leave the toggle state as it was for the next programming cycle.
- R8: After reset the toggle state is 0, so the first read access during programming shows bit 6 as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| rd_addr | input | 15 | Address of the current read |
| array_q | input | 8 | Array word at `rd_addr` |
| prog_busy | input | 1 | Internal programming cycle in progress |
| poll_block | input | 1 | Polling suppressed after a rejected protected write |
| last_addr | input | 15 | Address of the last byte written |
| last_msb | input | 1 | Bit 7 of the last byte written |
| bus_q | output | 8 | Data driven toward the pins |
| bus_oe | output | 1 | Enable for the tri-state output buffers |

## Verification
The bench tries the read path with reads at the last written address, reads at other addresses, and reads with the block flag set. These patterns separate real polling inversion from plain array data. It also uses single-cycle and multi-cycle accesses, with idle gaps between them. This shows that the toggle advances once per access and not once per clock. It drops only one strobe at a time to prove that both are needed to drive the bus. It also runs idle reads between two busy periods, to show that the toggle state carries over untouched.

// File: rtl/eeprom_wstat_pkg.sv
package eeprom_wstat_pkg;

  // Value of the polling bit during programming.
  function automatic logic poll_bit(input logic addr_hit, input logic blocked,
                                    input logic written_msb, input logic arr_msb);
    if (addr_hit && !blocked) return ~written_msb;
    return arr_msb;
  endfunction

  // Value of the toggle bit seen during an access.
  function automatic logic toggle_view(input logic held, input logic advance);
    return held ^ advance;
  endfunction

endpackage

// File: rtl/wstat_strobe_edge.sv
module wstat_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic oe_n,
  output logic rd_act,
  output logic acc_start
);
  logic rd_prev;

  assign rd_act    = ~cs_n & ~oe_n;
  assign acc_start = rd_act & ~rd_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_prev <= 1'b0;
    else        rd_prev <= rd_act;
  end

  // R3: a start is never reported on two consecutive cycles
  a_r3_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !acc_start);
endmodule

// File: rtl/wstat_toggle.sv
module wstat_toggle
  import eeprom_wstat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic acc_start,
  output logic tog_out
);
  logic tog_q;
  logic advance;

  assign advance = busy & acc_start;
  assign tog_out = toggle_view(tog_q, advance);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tog_q <= 1'b0;
    else if (advance) tog_q <= ~tog_q;
  end

  // R3: each access start during programming moves the held state
  a_r3_flip_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (tog_q != $past(tog_q)));
  // R7: held state is frozen while idle
  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tog_q));
endmodule

// File: rtl/wstat_status_mux.sv
module wstat_status_mux
  import eeprom_wstat_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_act,
  input  logic              busy,
  input  logic              blocked,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              last_msb,
  input  logic [DATA_W-1:0] array_q,
  input  logic              tog_bit,
  output logic [DATA_W-1:0] bus_q,
  output logic              bus_oe
);
  localparam int POLL_IDX = DATA_W - 1;
  localparam int TOG_IDX  = DATA_W - 2;
  localparam int RSV_W    = DATA_W - 2;

  logic addr_hit;
  assign addr_hit = (rd_addr == last_addr);
  assign bus_oe   = rd_act;

  always_comb begin
    bus_q = '0;
    if (rd_act) begin
      if (!busy) begin
        bus_q = array_q;
      end else begin
        bus_q[POLL_IDX]  = poll_bit(addr_hit, blocked, last_msb, array_q[POLL_IDX]);
        bus_q[TOG_IDX]   = tog_bit;
        bus_q[RSV_W-1:0] = '0;
      end
    end
  end

  // R1: an undriven bus carries zeros
  a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_q == '0));
  // R2: polling returns the inverse of the written top bit
  a_r2_poll_invert: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && busy && addr_hit && !blocked) |-> (bus_q[POLL_IDX] != last_msb));
  // R5: reserved bits low during status reads
  a_r5_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && busy) |-> (bus_q[RSV_W-1:0] == '0));
  // R7: idle reads pass the array word
  a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !busy) |-> (bus_q == array_q));
endmodule

// File: rtl/eeprom_wstat.sv
module eeprom_wstat #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_q,
  input  logic              prog_busy,
  input  logic              poll_block,
  input  logic [ADDR_W-1:0] last_addr,
  input  logic              last_msb,
  output logic [DATA_W-1:0] bus_q,
  output logic              bus_oe
);
  localparam int TOG_IDX = DATA_W - 2;

  logic rd_act;
  logic acc_start;
  logic tog_bit;

  wstat_strobe_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n),
    .rd_act(rd_act), .acc_start(acc_start)
  );

  wstat_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .busy(prog_busy),
    .acc_start(acc_start), .tog_out(tog_bit)
  );

  wstat_status_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .busy(prog_busy),
    .blocked(poll_block), .rd_addr(rd_addr), .last_addr(last_addr),
    .last_msb(last_msb), .array_q(array_q), .tog_bit(tog_bit),
    .bus_q(bus_q), .bus_oe(bus_oe)
  );

  // R4: toggle bit steady within one busy access
  a_r4_steady_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && prog_busy && $past(prog_busy) && bus_oe && $past(bus_oe))
      |-> $stable(bus_q[TOG_IDX]));
endmodule

// File: tb/eeprom_wstat_tb_top.sv
module eeprom_wstat_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int DW = 8;

  typedef struct {
    logic          en;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] rd_addr = '0, last_addr = '0;
  logic [DW-1:0] array_q = '0;
  logic          prog_busy = 1'b0, poll_block = 1'b0, last_msb = 1'b0;
  logic [DW-1:0] bus_q;
  logic          bus_oe;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   tog_m    = 1'b0;
  bit   prev_m   = 1'b0;
  bit   done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_wstat dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .rd_addr(rd_addr),
    .array_q(array_q), .prog_busy(prog_busy), .poll_block(poll_block),
    .last_addr(last_addr), .last_msb(last_msb), .bus_q(bus_q), .bus_oe(bus_oe)
  );

  // Drive one cycle of inputs and queue what the bus should show.
  task automatic step(input bit cs, input bit oe, input logic [AW-1:0] a,
                      input logic [DW-1:0] arr, input string tag);
    exp_t e;
    bit act, start, t6, b7;
    @(posedge clk); #1;
    cs_n = cs; oe_n = oe; rd_addr = a; array_q = arr;
    act   = (cs == 1'b0) && (oe == 1'b0);
    start = act && !prev_m && rst_n;
    t6    = tog_m;
    if (start && prog_busy) t6 = !tog_m;
    e.en  = act;
    e.tag = tag;
    if (!act)            e.d = 8'h00;
    else if (!prog_busy) e.d = arr;
    else begin
      b7 = ((a == last_addr) && !poll_block) ? !last_msb : arr[7];
      e.d = 8'h00 + (b7 ? 8'd128 : 8'd0) + (t6 ? 8'd64 : 8'd0);
    end
    exp_q.push_back(e);
    tog_m  = t6;
    prev_m = act && rst_n;
  endtask

  task automatic gap(input string tag);
    step(1'b1, 1'b1, rd_addr, array_q, tag);
  endtask

  // Monitor: compare away from the active edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (bus_oe !== e.en || bus_q !== e.d) begin
        n_fail++;
        $display("FAIL %s: got oe=%0b q=%02h, expected oe=%0b q=%02h",
                 e.tag, bus_oe, bus_q, e.en, e.d);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R8 / R1: reset state, bus idle
    step(1'b1, 1'b1, 15'h0000, 8'h00, "R8 reset idle");
    step(1'b1, 1'b1, 15'h0000, 8'h00, "R8 reset idle");
    rst_n = 1'b1;
    gap("R1 idle after reset");

    // R7: idle read passes the array word
    step(1'b0, 1'b0, 15'h0100, 8'h5A, "R7 idle read");
    step(1'b0, 1'b0, 15'h0100, 8'h5A, "R7 idle read hold");
    // R1: one strobe alone does not drive
    step(1'b0, 1'b1, 15'h0100, 8'h5A, "R1 oe high");
    step(1'b1, 1'b0, 15'h0100, 8'h5A, "R1 cs high");
    gap("R1 gap");

    // Start programming
    last_addr = 15'h1234; last_msb = 1'b0; prog_busy = 1'b1;
    gap("R1 busy gap");
    // R2 R3 R8: first busy access, toggle reads 1, polling inverted
    step(1'b0, 1'b0, 15'h1234, 8'hFF, "R8 R2 first busy read");
    step(1'b0, 1'b0, 15'h1234, 8'hFF, "R4 long access");
    step(1'b0, 1'b0, 15'h1234, 8'hFF, "R4 long access");
    gap("R1 gap");
    step(1'b0, 1'b0, 15'h1234, 8'hFF, "R3 second access");
    gap("R1 gap");
    // R6: other address shows array bit 7
    step(1'b0, 1'b0, 15'h0042, 8'h7F, "R6 address mismatch");
    step(1'b0, 1'b0, 15'h0042, 8'h7F, "R5 reserved low");
    gap("R1 gap");
    // R6: blocked polling
    poll_block = 1'b1;
    step(1'b0, 1'b0, 15'h1234, 8'h00, "R6 poll blocked");
    gap("R1 gap");
    poll_block = 1'b0;
    // R2: written top bit 1 reads back 0
    last_msb = 1'b1;
    step(1'b0, 1'b0, 15'h1234, 8'hFF, "R2 msb one inverted");
    gap("R1 gap");
    // R7: programming ends, reads are plain and toggle holds
    prog_busy = 1'b0;
    step(1'b0, 1'b0, 15'h1234, 8'hC3, "R7 done true data");
    gap("R1 gap");
    step(1'b0, 1'b0, 15'h1234, 8'h3C, "R7 idle second read");
    gap("R1 gap");
    prog_busy = 1'b1;
    step(1'b0, 1'b0, 15'h1234, 8'h00, "R7 toggle held across idle");
    step(1'b0, 1'b0, 15'h1234, 8'h00, "R4 steady");
    gap("R1 final gap");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule